// File: doc/BRIEF.md
# Byte-Bus Address Decoder with Boot Overlay

This block sits between an 8-bit processor core and its on-chip storage. It takes a 16-bit byte address with separate read and write strobes and steers each access to one region: a small start-up program that overlays the bottom of program ROM, the program ROM itself, video RAM, work RAM with a second alias window, sprite attribute RAM, a bank of I/O registers, a fast scratch RAM and an interrupt-enable byte. Unused windows return fixed fill values and drop writes.

Both ROMs are computed from the address at elaboration time, so no memory file is needed. Program ROM byte = `addr[7:0] ^ addr[15:8] ^ CART_KEY`. Start-up ROM byte = `addr[7:0] ^ BOOT_KEY`. The start-up overlay is on after reset and is switched off by any write to 0xFF50. It stays off until the next reset.

A `userMode` input selects how I/O writes are treated. When it is low, every I/O write is stored as given. When it is high, per-register rules apply: a clear-on-write register, read-only and mixed registers that ignore writes, and a debug serial port that emits one character. Reads are combinational. Writes take effect on the rising clock edge.

Top module: `busdec_top`

## Requirements
- R1: While the overlay is on, a ROM read below BOOT_LEN (default 256) returns `addr[7:0]^BOOT_KEY`. Any other read in 0x0000–0x7FFF returns `addr[7:0]^addr[15:8]^CART_KEY` (defaults 0xA5 and 0x3C).
- R2: The overlay is on after reset. Any write to 0xFF50 turns it off from the next cycle on, and only a reset turns it on again.
- R3: Writes to 0x0000–0x7FFF and to 0xA000–0xBFFF change nothing. Reads in 0xA000–0xBFFF return 0xFF.
- R4: Video RAM at 0x8000–0x9FFF returns the last byte written at offset `(addr-0x8000) mod VRAM_DEPTH`.
- R5: Work RAM at 0xC000–0xDFFF uses offset `addr-0xC000`. The alias window 0xE000–0xFDFF uses offset `addr-0xE000` for both reads and writes. Both offsets are taken mod WRAM_DEPTH.
- R6: Sprite RAM at 0xFE00–0xFE9F stores and returns 160 bytes.
- R7: Reads in 0xFEA0–0xFEFF return 0x00. Reads in 0xFF4C–0xFF7F return 0xFF. Writes to both ranges store nothing.
- R8: Scratch RAM at 0xFF80–0xFFFE stores 127 bytes. The interrupt-enable byte at 0xFFFF is writable and resets to 0x00.
- R9: I/O registers 0xFF00–0xFF4B reset to 0xFF. A read of 0xFF00 returns 0xFF whatever was written there.
- R10: With `userMode` low, every write in 0xFF00–0xFF4B is stored unchanged. This includes 0xFF02, 0xFF04 and 0xFF44, and a write to 0xFF02 does not emit.
- R11: With `userMode` high, a write to 0xFF04 stores 0x00, and a write to 0xFF02 is not stored. Writes to 0xFF44, 0xFF00, 0xFF11, 0xFF14, 0xFF16, 0xFF19, 0xFF1E, 0xFF23, 0xFF26 and 0xFF41 are not stored. Any other I/O write is stored.
- R12: With `userMode` high, writing 0x81 to 0xFF02 raises `emitValid` for exactly the following cycle, with `emitChar` equal to the value of 0xFF01 at the write. Any other value written there emits nothing.
- R13: `rdData` is 0x00 whenever `rdEn` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 16 | Byte address |
| wrData | input | 8 | Write data |
| rdEn | input | 1 | Read strobe |
| wrEn | input | 1 | Write strobe, taken on the rising edge |
| userMode | input | 1 | Selects the per-register I/O write rules |
| rdData | output | 8 | Combinational read data |
| emitValid | output | 1 | One-cycle debug character strobe |
| emitChar | output | 8 | Character shown with `emitValid` |

## Verification
The bench checks the edges of each window: 0x7FFF against 0x8000, 0xFE9F against 0xFEA0, 0xFF4B against 0xFF4C, and 0xFFFE against 0xFFFF. An off-by-one decoder would return fill values or stale RAM there. It writes through the alias window and reads back through the main work RAM window, which exposes a mirror that uses the wrong base. It drives the same I/O addresses with `userMode` low and then high, so a rule applied in the wrong mode shows up as a stored or dropped byte. Finally it turns the overlay off, confirms that a ROM write does not turn it back on, and resets to confirm that it returns.

// File: rtl/busdec_pkg.sv
package busdec_pkg;

  typedef enum logic [3:0] {
    RG_ROM, RG_VRAM, RG_FILL_FF, RG_WRAM, RG_OAM,
    RG_FILL_00, RG_IO, RG_HRAM, RG_IE
  } region_e;

  typedef struct packed {
    logic wrVram;
    logic wrWram;
    logic wrOam;
    logic wrHram;
    logic wrIo;
    logic ioZero;
    logic wrIe;
    logic clearBoot;
    logic emit;
  } strobes_t;

endpackage

// File: rtl/busdec_ctrl.sv
module busdec_ctrl
  import busdec_pkg::*;
(
  input  logic [15:0] addr,
  input  logic [7:0]  wrData,
  input  logic        wrEn,
  input  logic        userMode,
  output region_e     region,
  output strobes_t    stb
);

  always_comb begin
    if (addr < 16'h8000)      region = RG_ROM;
    else if (addr < 16'hA000) region = RG_VRAM;
    else if (addr < 16'hC000) region = RG_FILL_FF;
    else if (addr < 16'hFE00) region = RG_WRAM;
    else if (addr < 16'hFEA0) region = RG_OAM;
    else if (addr < 16'hFF00) region = RG_FILL_00;
    else if (addr < 16'hFF4C) region = RG_IO;
    else if (addr < 16'hFF80) region = RG_FILL_FF;
    else if (addr < 16'hFFFF) region = RG_HRAM;
    else                      region = RG_IE;
  end

  always_comb begin
    stb = '0;
    stb.clearBoot = wrEn && (addr == 16'hFF50);
    if (wrEn) begin
      unique case (region)
        RG_VRAM: stb.wrVram = 1'b1;
        RG_WRAM: stb.wrWram = 1'b1;
        RG_OAM:  stb.wrOam  = 1'b1;
        RG_HRAM: stb.wrHram = 1'b1;
        RG_IE:   stb.wrIe   = 1'b1;
        RG_IO: begin
          if (!userMode) begin
            stb.wrIo = 1'b1;
          end else begin
            case (addr[7:0])
              8'h02: stb.emit = (wrData == 8'h81);
              8'h04: begin stb.wrIo = 1'b1; stb.ioZero = 1'b1; end
              8'h00, 8'h11, 8'h14, 8'h16, 8'h19,
              8'h1E, 8'h23, 8'h26, 8'h41, 8'h44: stb.wrIo = 1'b0;
              default: stb.wrIo = 1'b1;
            endcase
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/busdec_dp.sv
module busdec_dp
  import busdec_pkg::*;
#(
  parameter int          BOOT_LEN    = 256,
  parameter logic [7:0]  BOOT_KEY    = 8'hA5,
  parameter logic [7:0]  CART_KEY    = 8'h3C,
  parameter int          VRAM_DEPTH  = 2048,
  parameter int          WRAM_DEPTH  = 2048
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [15:0] addr,
  input  logic [7:0]  wrData,
  input  logic        rdEn,
  input  logic        wrEn,
  input  logic        userMode,
  input  region_e     region,
  input  strobes_t    stb,
  output logic [7:0]  rdData,
  output logic        emitValid,
  output logic [7:0]  emitChar
);

  localparam int VA = $clog2(VRAM_DEPTH);
  localparam int WA = $clog2(WRAM_DEPTH);
  localparam int IO_COUNT = 76;
  localparam int OAM_COUNT = 160;
  localparam int HRAM_COUNT = 127;
  localparam logic [31:0] BOOT_END = BOOT_LEN;

  logic [7:0] vram [VRAM_DEPTH];
  logic [7:0] wram [WRAM_DEPTH];
  logic [7:0] oam  [OAM_COUNT];
  logic [7:0] hram [HRAM_COUNT];
  logic [7:0] ioReg [IO_COUNT];
  logic [7:0] ieReg;
  logic       bootOn;

  logic [15:0] vOff, wOff;
  logic [VA-1:0] vIdx;
  logic [WA-1:0] wIdx;
  logic [7:0] romByte;

  assign vOff = addr - 16'h8000;
  assign wOff = (addr >= 16'hE000) ? (addr - 16'hE000) : (addr - 16'hC000);
  assign vIdx = vOff[VA-1:0];
  assign wIdx = wOff[WA-1:0];

  always_comb begin
    if (bootOn && ({16'b0, addr} < BOOT_END)) romByte = addr[7:0] ^ BOOT_KEY;
    else romByte = addr[7:0] ^ addr[15:8] ^ CART_KEY;
  end

  always_ff @(posedge clk) begin
    if (stb.wrVram) vram[vIdx] <= wrData;
    if (stb.wrWram) wram[wIdx] <= wrData;
    if (stb.wrOam)  oam[addr[7:0]] <= wrData;
    if (stb.wrHram) hram[addr[6:0]] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < IO_COUNT; i++) ioReg[i] <= 8'hFF;
      ieReg     <= 8'h00;
      bootOn    <= 1'b1;
      emitValid <= 1'b0;
      emitChar  <= 8'h00;
    end else begin
      if (stb.wrIo) ioReg[addr[6:0]] <= stb.ioZero ? 8'h00 : wrData;
      if (stb.wrIe) ieReg <= wrData;
      if (stb.clearBoot) bootOn <= 1'b0;
      emitValid <= stb.emit;
      if (stb.emit) emitChar <= ioReg[1];
    end
  end

  always_comb begin
    rdData = 8'h00;
    if (rdEn) begin
      unique case (region)
        RG_ROM:     rdData = romByte;
        RG_VRAM:    rdData = vram[vIdx];
        RG_FILL_FF: rdData = 8'hFF;
        RG_WRAM:    rdData = wram[wIdx];
        RG_OAM:     rdData = oam[addr[7:0]];
        RG_FILL_00: rdData = 8'h00;
        RG_IO:      rdData = (addr[6:0] == 7'd0) ? 8'hFF : ioReg[addr[6:0]];
        RG_HRAM:    rdData = hram[addr[6:0]];
        RG_IE:      rdData = ieReg;
        default:    rdData = 8'h00;
      endcase
    end
  end

  // R2
  boot_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (wrEn && addr == 16'hFF50) |=> !bootOn);

  // R2
  boot_norise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(bootOn) |-> $past(rst));

  // R11
  io_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (wrEn && userMode && addr == 16'hFF04) |=> (ioReg[4] == 8'h00));

  // R11
  ro_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wrEn && userMode && addr == 16'hFF44) |=> $stable(ioReg[68]));

  // R12
  emit_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (wrEn && userMode && addr == 16'hFF02 && wrData == 8'h81)
      |=> (emitValid && emitChar == $past(ioReg[1])));

  // R12
  emit_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !(wrEn && userMode && addr == 16'hFF02 && wrData == 8'h81) |=> !emitValid);

  // R13
  always_comb begin
    rd_idle_chk: assert (rdEn || rdData == 8'h00);
  end

endmodule

// File: rtl/busdec_top.sv
module busdec_top
  import busdec_pkg::*;
#(
  parameter int          BOOT_LEN   = 256,
  parameter logic [7:0]  BOOT_KEY   = 8'hA5,
  parameter logic [7:0]  CART_KEY   = 8'h3C,
  parameter int          VRAM_DEPTH = 2048,
  parameter int          WRAM_DEPTH = 2048
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [15:0] addr,
  input  logic [7:0]  wrData,
  input  logic        rdEn,
  input  logic        wrEn,
  input  logic        userMode,
  output logic [7:0]  rdData,
  output logic        emitValid,
  output logic [7:0]  emitChar
);

  region_e  region;
  strobes_t stb;

  busdec_ctrl u_ctrl (
    .addr(addr), .wrData(wrData), .wrEn(wrEn), .userMode(userMode),
    .region(region), .stb(stb)
  );

  busdec_dp #(
    .BOOT_LEN(BOOT_LEN), .BOOT_KEY(BOOT_KEY), .CART_KEY(CART_KEY),
    .VRAM_DEPTH(VRAM_DEPTH), .WRAM_DEPTH(WRAM_DEPTH)
  ) u_dp (
    .clk(clk), .rst(rst), .addr(addr), .wrData(wrData), .rdEn(rdEn),
    .wrEn(wrEn), .userMode(userMode), .region(region), .stb(stb),
    .rdData(rdData), .emitValid(emitValid), .emitChar(emitChar)
  );

endmodule

// File: tb/sim_busdec_top.sv
module sim_busdec_top;

  localparam int BL = 256;
  localparam int VD = 2048;
  localparam int WD = 2048;
  localparam logic [7:0] BK = 8'hA5;
  localparam logic [7:0] CK = 8'h3C;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] addr = 16'h0000;
  logic [7:0] wrData = 8'h00;
  logic rdEn = 1'b0, wrEn = 1'b0, userMode = 1'b0;
  logic [7:0] rdData, emitChar;
  logic emitValid;

  always #10 clk = ~clk;

  busdec_top u0 (
    .clk(clk), .rst(rst), .addr(addr), .wrData(wrData), .rdEn(rdEn),
    .wrEn(wrEn), .userMode(userMode), .rdData(rdData),
    .emitValid(emitValid), .emitChar(emitChar)
  );

  int nChecks = 0, nFails = 0;
  bit finished = 0;

  // behavioural reference state
  byte unsigned vramM[int], wramM[int], oamM[int], hramM[int];
  byte unsigned ioM[76];
  byte unsigned ieM;
  bit bootM;
  bit expEmit;
  byte unsigned expChar;

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic byte unsigned modelRead(int a);
    if (a < 'h8000) begin
      if (bootM && a < BL) return byte'(a[7:0] ^ BK);
      return byte'(a[7:0] ^ a[15:8] ^ CK);
    end
    if (a < 'hA000) return vramM.exists((a - 'h8000) % VD) ? vramM[(a - 'h8000) % VD] : 8'h00;
    if (a < 'hC000) return 8'hFF;
    if (a < 'hFE00) begin
      int o = (a >= 'hE000) ? (a - 'hE000) % WD : (a - 'hC000) % WD;
      return wramM.exists(o) ? wramM[o] : 8'h00;
    end
    if (a < 'hFEA0) return oamM.exists(a - 'hFE00) ? oamM[a - 'hFE00] : 8'h00;
    if (a < 'hFF00) return 8'h00;
    if (a == 'hFF00) return 8'hFF;
    if (a < 'hFF4C) return ioM[a - 'hFF00];
    if (a < 'hFF80) return 8'hFF;
    if (a < 'hFFFF) return hramM.exists(a - 'hFF80) ? hramM[a - 'hFF80] : 8'h00;
    return ieM;
  endfunction

  function automatic void modelWrite(int a, byte unsigned d);
    if (a == 'hFF50) bootM = 0;
    if (a >= 'h8000 && a < 'hA000) vramM[(a - 'h8000) % VD] = d;
    else if (a >= 'hC000 && a < 'hFE00)
      wramM[(a >= 'hE000) ? (a - 'hE000) % WD : (a - 'hC000) % WD] = d;
    else if (a >= 'hFE00 && a < 'hFEA0) oamM[a - 'hFE00] = d;
    else if (a >= 'hFF80 && a < 'hFFFF) hramM[a - 'hFF80] = d;
    else if (a == 'hFFFF) ieM = d;
    else if (a >= 'hFF00 && a < 'hFF4C) begin
      if (!userMode) ioM[a - 'hFF00] = d;
      else case (a)
        'hFF02: if (d == 8'h81) begin expEmit = 1; expChar = ioM[1]; end
        'hFF04: ioM[4] = 8'h00;
        'hFF00, 'hFF11, 'hFF14, 'hFF16, 'hFF19, 'hFF1E,
        'hFF23, 'hFF26, 'hFF41, 'hFF44: ;
        default: ioM[a - 'hFF00] = d;
      endcase
    end
  endfunction

  function automatic void modelReset();
    foreach (ioM[i]) ioM[i] = 8'hFF;
    ieM = 8'h00;
    bootM = 1;
    expEmit = 0;
  endfunction

  // one clock; emit output compared on every cycle (R12)
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    check("R12 emitValid", int'(emitValid), int'(expEmit));
    if (expEmit) check("R12 emitChar", int'(emitChar), int'(expChar));
    expEmit = 0;
  endtask

  task automatic wr(int a, byte unsigned d);
    addr = 16'(a); wrData = d; wrEn = 1; rdEn = 0;
    modelWrite(a, d);
    step();
    wrEn = 0;
  endtask

  task automatic rd(int a, string req);
    addr = 16'(a); rdEn = 1; wrEn = 0;
    #1;
    check(req, int'(rdData), int'(modelRead(a)));
    step();
    rdEn = 0;
  endtask

  task automatic doReset();
    rst = 1; wrEn = 0; rdEn = 0;
    modelReset();
    step(); step();
    rst = 0;
  endtask

  initial begin
    @(negedge clk);
    doReset();
    // reset state
    rd('hFF00, "R9 reset FF00");
    rd('hFF05, "R9 reset io");
    rd('hFF4B, "R9 reset last io");
    rd('hFFFF, "R8 ie reset");
    rd('h0010, "R1 boot byte");
    rd('h00FF, "R1 boot last");
    rd('h0100, "R1 cart past boot");
    rd('h7FFF, "R1 cart top");
    addr = 16'h0010; rdEn = 0; #1;
    check("R13 idle read", int'(rdData), 0);
    step();
    // R4 video RAM
    for (int i = 0; i < 8; i++) wr('h8000 + i * 'h111, byte'(8'h10 + i * 7));
    wr('h9FFF, 8'hC3);
    for (int i = 0; i < 8; i++) rd('h8000 + i * 'h111, "R4 vram");
    rd('h9FFF, "R4 vram top");
    // R5 work RAM and alias
    wr('hC005, 8'h12);
    rd('hE005, "R5 alias read");
    wr('hE123, 8'h9A);
    rd('hC123, "R5 alias write");
    wr('hFDFF, 8'h77);
    rd('hDDFF, "R5 alias top");
    rd('hFDFF, "R5 alias top self");
    // R6 sprite RAM
    wr('hFE00, 8'h01); wr('hFE9F, 8'h9F);
    rd('hFE00, "R6 oam first"); rd('hFE9F, "R6 oam last");
    // R7 fill windows
    wr('hFEA0, 8'h55); rd('hFEA0, "R7 zero fill"); rd('hFEFF, "R7 zero fill end");
    wr('hFF4C, 8'h55); rd('hFF4C, "R7 ff fill"); rd('hFF7F, "R7 ff fill end");
    rd('hFE9F, "R7 oam untouched");
    // R3 ignored writes
    wr('hA000, 8'h11); rd('hA000, "R3 ext read"); rd('hBFFF, "R3 ext end");
    wr('h0010, 8'h99); rd('h0010, "R3 rom write ignored");
    // R8 scratch and ie
    wr('hFF80, 8'h21); wr('hFFFE, 8'hE1); wr('hFFFF, 8'h1F);
    rd('hFF80, "R8 hram first"); rd('hFFFE, "R8 hram last"); rd('hFFFF, "R8 ie");
    // R10 plain mode
    userMode = 0;
    wr('hFF04, 8'h5A); rd('hFF04, "R10 store 04");
    wr('hFF44, 8'h33); rd('hFF44, "R10 store 44");
    wr('hFF01, 8'h41);
    wr('hFF02, 8'h81); rd('hFF02, "R10 store 02 no emit");
    wr('hFF00, 8'h00); rd('hFF00, "R9 FF00 forced");
    // R11 user mode rules
    userMode = 1;
    wr('hFF04, 8'h77); rd('hFF04, "R11 clear 04");
    wr('hFF44, 8'h12); rd('hFF44, "R11 ro 44");
    wr('hFF11, 8'h00); rd('hFF11, "R11 mixed 11");
    wr('hFF41, 8'h00); rd('hFF41, "R11 mixed 41");
    wr('hFF26, 8'h00); rd('hFF26, "R11 mixed 26");
    wr('hFF05, 8'h42); rd('hFF05, "R11 plain store");
    // R12 emit
    wr('hFF01, 8'h48);
    wr('hFF02, 8'h81);
    wr('hFF02, 8'h80);
    wr('hFF01, 8'h69);
    wr('hFF02, 8'h81); wr('hFF02, 8'h81);
    rd('hFF02, "R11 02 not stored");
    step();
    // R2 overlay
    wr('hFF50, 8'h00);
    rd('h0010, "R2 overlay off");
    rd('hFF50, "R7 FF50 reads fill");
    wr('h0000, 8'h01);
    rd('h0020, "R2 stays off");
    doReset();
    rd('h0010, "R2 overlay back");
    rd('hFFFF, "R8 ie after reset");
    rd('hFF04, "R9 io after reset");
    finished = 1;
    $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

endmodule